// File: doc/BRIEF.md
# 64-bit MII Transmit Frame Encoder

This block turns Ethernet frame bytes from a byte-stream source into the lane-ordered word stream of a 64-bit MII transmit sink. The source hands over eight bytes per beat and marks each beat with a first-beat flag, a last-beat flag and a per-lane keep mask. An eight-entry buffer absorbs these beats. The encoder then writes one 64-bit data word and eight per-lane control flags for every cycle in which the sink is being fed.

For every frame the encoder first sends a start word that holds the start character, the preamble and the start-frame delimiter. It then sends the payload with the byte order kept, and closes the frame with a terminate character. Idle characters fill the rest of the closing word and every word sent between frames. The sink paces the stream through a ready input. The valid output copies ready after a fixed delay of one to six cycles, set by a parameter. No word advances while valid is low. The alignment-marker output is held low because no forward error correction is used.

Top module: `mii64_tx_framer`

## Requirements
- R1: While reset is held, mii_valid is 0, mii_d holds 0x07 in every lane, mii_c is 0xFF and in_ready is 1.
- R2: mii_valid in any cycle equals the mii_ready value sampled LAT clock edges earlier, where LAT is a parameter in the range 1 to 6.
- R3: A new word is loaded only at the edges where mii_valid becomes or stays high. While mii_valid is low, mii_d and mii_c hold their previous values.
- R4: A frame opens with a start word. Lane 0 (mii_d[7:0], the first byte on the line) carries 0xFB with mii_c[0]=1. Lanes 1 to 6 carry 0x55 and lane 7 carries 0xD5, all with their control bits 0. The first payload beat follows in the next valid word.
- R5: Each payload beat goes out as one word. Byte lane k of in_data[8k+7:8k] appears in lane k of mii_d with mii_c[k]=0.
- R6: Let n be the number of set bits of in_keep on the last beat. That mask must be contiguous from bit 0. If n<8, lane n carries 0xFD with control set and lanes above n carry 0x07 with control set. If n=8, the next valid word carries 0xFD in lane 0 and 0x07 in lanes 1 to 7, all with control set.
- R7: When no frame is in progress and the buffer holds no first beat, each valid word is all-idle (0x07 in every lane, mii_c=0xFF).
- R8: If the buffer is empty when a payload word is due inside a frame, the word sent is 0xFE in every lane with mii_c=0xFF, and the frame resumes when data arrives.
- R9: A beat that reaches the encoder outside a frame without its first-beat flag is discarded, and an idle word is sent in its place.
- R10: in_ready is low exactly while the eight-entry buffer is full. Every beat offered with in_ready high is later sent.
- R11: mii_am is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | Beat bytes, lane 0 first |
| in_keep | input | 8 | Valid lanes of a last beat, contiguous from bit 0 |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Buffer can take a beat |
| mii_ready | input | 1 | Sink request to be fed |
| mii_d | output | 64 | MII data lanes |
| mii_c | output | 8 | Per-lane control flags |
| mii_valid | output | 1 | Word qualifier, mii_ready delayed by LAT |
| mii_am | output | 1 | Alignment-marker request, held low |

## Verification
Frame lengths from 1 to 17 bytes and 40 and 64 bytes cover every remainder modulo 8. This separates the in-word terminate from the extra terminate word that follows a full last beat. The same frames are run under a constantly high ready and under a random ready. Under the random ready, a wrong latency or a word that moves while valid is low shows up as a difference from the model in a particular cycle. A stray beat without a first-beat flag, a bubble inside a frame and a long stretch of ready low each drive one of the corner paths: the discard path, the error word, and buffer-full backpressure with no loss.

// File: rtl/mii64_tx_framer.sv
module mii64_tx_framer #(
  parameter int LAT = 3,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] in_data,
  input  logic [7:0]  in_keep,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        mii_ready,
  output logic [63:0] mii_d,
  output logic [7:0]  mii_c,
  output logic        mii_valid,
  output logic        mii_am
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [63:0] IDLE_W  = {8{8'h07}};
  localparam logic [63:0] START_W = {8'hD5, {6{8'h55}}, 8'hFB};
  localparam logic [63:0] ERR_W   = {8{8'hFE}};

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TERM} st_t;

  st_t st, nst;
  logic [63:0] f_d [DEPTH];
  logic [7:0]  f_k [DEPTH];
  logic [DEPTH-1:0] f_s, f_e;
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic [LAT-1:0] sh;
  logic [LAT:0] chain;
  logic adv, push, pop, rd_en, empty;
  logic [63:0] nd;
  logic [7:0] nc;
  logic [3:0] nl;

  assign chain = {sh, mii_ready};
  assign adv = chain[LAT-1];
  assign mii_valid = sh[LAT-1];
  assign mii_am = 1'b0;
  assign empty = (cnt == '0);
  assign in_ready = (cnt != CW'(DEPTH));
  assign push = in_valid && in_ready;
  assign rd_en = adv && pop;

  always_comb begin
    nl = 4'd8;
    if (f_e[rp])
      for (int k = 7; k >= 0; k--)
        if (!f_k[rp][k]) nl = 4'(k);
  end

  always_comb begin
    nst = st;
    nd = IDLE_W;
    nc = 8'hFF;
    pop = 1'b0;
    unique case (st)
      S_IDLE: if (!empty) begin
        if (f_s[rp]) begin
          nst = S_DATA;
          nd = START_W;
          nc = 8'h01;
        end else pop = 1'b1;
      end
      S_DATA: if (empty) nd = ERR_W;
      else begin
        pop = 1'b1;
        for (int k = 0; k < 8; k++) begin
          if (4'(k) < nl) begin
            nd[8*k +: 8] = f_d[rp][8*k +: 8];
            nc[k] = 1'b0;
          end else if (4'(k) == nl) nd[8*k +: 8] = 8'hFD;
        end
        if (f_e[rp]) nst = (nl == 4'd8) ? S_TERM : S_IDLE;
      end
      S_TERM: begin
        nd[7:0] = 8'hFD;
        nst = S_IDLE;
      end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_d[wp] <= in_data;
      f_k[wp] <= in_keep;
      f_s[wp] <= in_sop;
      f_e[wp] <= in_eop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      st <= S_IDLE;
      mii_d <= IDLE_W;
      mii_c <= 8'hFF;
      rp <= '0;
      wp <= '0;
      cnt <= '0;
    end else begin
      sh <= chain[LAT-1:0];
      if (adv) begin
        st <= nst;
        mii_d <= nd;
        mii_c <= nc;
      end
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(rd_en);
    end
  end

  logic [2:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'(LAT)) |-> (mii_valid == $past(mii_ready, LAT)));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !mii_valid |-> ($stable(mii_d) && $stable(mii_c)));

  a_r4_start_layout: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA && $past(st) == S_IDLE) |->
      (mii_d[7:0] == 8'hFB && mii_d[63:56] == 8'hD5 && mii_c == 8'h01));

  a_r6_term_word: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $past(st) == S_TERM) |->
      (mii_d[7:0] == 8'hFD && mii_c == 8'hFF));
endmodule

// File: tb/mii64_tx_framer_test.sv
module mii64_tx_framer_test;
  localparam int LAT = 3;
  localparam int DEPTH = 8;

  typedef struct {
    logic [63:0] d;
    logic [7:0] k;
    bit s, e, bub;
  } beat_t;

  logic clk = 0, rst = 1;
  logic [63:0] in_data = '0;
  logic [7:0] in_keep = '0;
  logic in_sop = 0, in_eop = 0, in_valid = 0, mii_ready = 0;
  logic in_ready, mii_valid, mii_am;
  logic [63:0] mii_d;
  logic [7:0] mii_c;

  mii64_tx_framer #(.LAT(LAT), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_keep(in_keep), .in_sop(in_sop),
    .in_eop(in_eop), .in_valid(in_valid), .in_ready(in_ready), .mii_ready(mii_ready),
    .mii_d(mii_d), .mii_c(mii_c), .mii_valid(mii_valid), .mii_am(mii_am));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int frames = 0, total_bytes = 0, fid = 0, rmode = 0;
  int fd_seen = 0, fb_seen = 0, fe_seen = 0, bytes_seen = 0;
  beat_t src[$], mf[$];
  bit rq[$];
  int mst = 0;
  logic [63:0] md = {8{8'h07}};
  logic [7:0] mc = 8'hFF;
  bit mv = 0;
  string kind = "R1";

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected less", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic add_frame(int len, int bub_after = -1);
    int nb = (len + 7) / 8;
    fid++;
    frames++;
    total_bytes += len;
    for (int i = 0; i < nb; i++) begin
      beat_t b;
      b.d = '0; b.k = '0; b.bub = 0;
      for (int l = 0; l < 8; l++)
        if (i * 8 + l < len) begin
          b.d[8*l +: 8] = 8'((fid * 31 + (i * 8 + l) * 7 + 1));
          b.k[l] = 1'b1;
        end
      b.s = (i == 0);
      b.e = (i == nb - 1);
      src.push_back(b);
      if (i == bub_after)
        for (int j = 0; j < 3; j++) begin
          beat_t z;
          z.d = '0; z.k = '0; z.s = 0; z.e = 0; z.bub = 1;
          src.push_back(z);
        end
    end
  endtask

  task automatic compare();
    chk(mii_valid === mv, "R2 valid latency", 72'(mii_valid), 72'(mv));
    chk(in_ready === (mf.size() < DEPTH), "R10 in_ready", 72'(in_ready), 72'(mf.size() < DEPTH));
    chk(mii_am === 1'b0, "R11 am low", 72'(mii_am), 72'(0));
    chk({mii_c, mii_d} === {mc, md}, kind, {mii_c, mii_d}, {mc, md});
    if (mii_valid) begin
      if (mii_c == 8'h01 && mii_d[7:0] == 8'hFB) fb_seen++;
      else
        for (int l = 0; l < 8; l++) begin
          if (!mii_c[l]) bytes_seen++;
          else if (mii_d[8*l +: 8] == 8'hFD) fd_seen++;
          else if (mii_d[8*l +: 8] == 8'hFE) fe_seen++;
        end
    end
  endtask

  task automatic drive();
    in_valid = 0;
    if (src.size() > 0) begin
      if (src[0].bub) void'(src.pop_front());
      else begin
        in_data = src[0].d; in_keep = src[0].k;
        in_sop = src[0].s; in_eop = src[0].e; in_valid = 1;
      end
    end
    case (rmode)
      0: mii_ready = 1;
      1: mii_ready = ($urandom % 3) != 0;
      default: mii_ready = 0;
    endcase
  endtask

  task automatic compute();
    bit acc = in_valid && (mf.size() < DEPTH);
    bit adv;
    rq.push_back(mii_ready);
    adv = rq.pop_front();
    mv = adv;
    if (!adv) kind = "R3 hold";
    else begin
      md = {8{8'h07}}; mc = 8'hFF;
      case (mst)
        0: if (mf.size() > 0 && mf[0].s) begin
             md = {8'hD5, {6{8'h55}}, 8'hFB}; mc = 8'h01; mst = 1; kind = "R4 start";
           end else if (mf.size() > 0) begin
             void'(mf.pop_front()); kind = "R9 discard";
           end else kind = "R7 idle";
        1: if (mf.size() == 0) begin
             md = {8{8'hFE}}; kind = "R8 underrun";
           end else begin
             beat_t b = mf.pop_front();
             int n = b.e ? $countones(b.k) : 8;
             for (int l = 0; l < 8; l++)
               if (l < n) begin md[8*l +: 8] = b.d[8*l +: 8]; mc[l] = 0; end
               else if (l == n) md[8*l +: 8] = 8'hFD;
             kind = b.e ? "R6 last beat" : "R5 payload";
             if (b.e) mst = (n == 8) ? 2 : 0;
           end
        default: begin
          md[7:0] = 8'hFD; mst = 0; kind = "R6 term word";
        end
      endcase
    end
    if (acc) begin
      mf.push_back(src.pop_front());
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    drive();
    compute();
  endtask

  task automatic drain(int extra);
    while (src.size() > 0) step();
    repeat (extra) step();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(mii_valid === 0, "R1 reset valid", 72'(mii_valid), 72'(0));
    chk(mii_d === {8{8'h07}}, "R1 reset data", 72'(mii_d), 72'({8{8'h07}}));
    chk(mii_c === 8'hFF, "R1 reset ctl", 72'(mii_c), 72'(8'hFF));
    chk(in_ready === 1, "R1 reset in_ready", 72'(in_ready), 72'(1));
    rst = 0;
    for (int i = 0; i < LAT - 1; i++) rq.push_back(0);
    compute();
    repeat (10) step();

    rmode = 0;
    for (int len = 1; len <= 17; len++) add_frame(len);
    add_frame(64);
    drain(30);

    rmode = 1;
    for (int len = 1; len <= 16; len++) add_frame(len * 3);
    drain(40);

    rmode = 0;
    begin
      beat_t s;
      s.d = 64'h0123456789ABCDEF; s.k = 8'hFF; s.s = 0; s.e = 0; s.bub = 0;
      src.push_back(s);
    end
    add_frame(9);
    drain(20);

    add_frame(24, 0);
    drain(20);

    rmode = 2;
    repeat (3) add_frame(40);
    repeat (40) step();
    chk(in_ready === 0, "R10 full stalls source", 72'(in_ready), 72'(0));
    rmode = 1;
    drain(40);
    rmode = 0;
    repeat (60) step();

    chk(fb_seen == frames, "R4 start count", 72'(fb_seen), 72'(frames));
    chk(fd_seen == frames, "R6 terminate count", 72'(fd_seen), 72'(frames));
    chk(bytes_seen == total_bytes, "R5 payload bytes", 72'(bytes_seen), 72'(total_bytes));
    chk(fe_seen > 0, "R8 error word seen", 72'(fe_seen), 72'(1));
    chk(mf.size() == 0, "R10 nothing lost", 72'(mf.size()), 72'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule